// File: doc/BRIEF.md
# Dual-Rail Pipelined Parallel-Prefix Adder

This block adds two W-bit operands and a carry-in, where every bit travels as a dual-rail pair: the true rail high means logic 1, the false rail high means logic 0, and both rails low means "empty". The adder is a chain of eight half-buffer stages. Each stage follows a four-phase handshake. It captures a token only when every input pair is valid and the stage after it has withdrawn its acknowledge. It returns to empty only when every input pair is empty and the stage after it acknowledges. A sampling clock stands in for gate delays, so each stage settles in one clock cycle.

Stage 1 forms bitwise propagate and generate. It folds the carry-in into the generate of bit 0. Stages 2 to 7 are the six Kogge-Stone combining levels, with spans 1, 2, 4, 8, 16 and 32. Group generate is an AND-OR of the upper and lower spans, group propagate is an AND, and positions without a partner pass through as buffers. Stage 8 forms the sum with XOR and takes the carry-out from the top group generate. Each stage builds its acknowledge with a Muller C-element over its own completion. A producer drives a token, waits for `in_ack` to rise, drives empty, and waits for `in_ack` to fall. A consumer reads a valid result, raises `out_ack`, waits for the outputs to become empty, and then lowers `out_ack`.

Top module: `ks_dr_adder`

## Requirements
- R1: After reset, every sum and carry-out rail is low and `in_ack` is low.
- R2: A result token carries `sum_t` = (A + B + Cin) mod 2^W and `cout_t` = bit W of that total, with each false rail equal to the complement of its true rail.
- R3: While any input pair is still empty, the first stage captures nothing: `in_ack` stays low and the outputs stay empty.
- R4: `in_ack` rises only in the cycle after a complete input token was present, and falls only in the cycle after the inputs were all empty.
- R5: A valid result holds unchanged on the outputs for as long as `out_ack` stays low.
- R6: While `out_ack` is high and the outputs are empty, no new result appears.
- R7: With an empty pipeline and `out_ack` low, a result becomes valid after exactly 8 clock edges from the edge that first samples a complete input, and not after 7.
- R8: Results come out in input order, exactly one per accepted input token, under any timing of the acknowledges.
- R9: No output pair ever has both rails high, and the output bank is either entirely valid or entirely empty.
- R10: With `out_ack` held low, the pipeline accepts exactly 4 tokens (half its stage count); a fifth token gets no `in_ack` until results drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock standing in for gate delays |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa_t | input | W | Operand A, true rails |
| opa_f | input | W | Operand A, false rails |
| opb_t | input | W | Operand B, true rails |
| opb_f | input | W | Operand B, false rails |
| cin_t | input | 1 | Carry-in, true rail |
| cin_f | input | 1 | Carry-in, false rail |
| in_ack | output | 1 | Acknowledge toward the producer |
| sum_t | output | W | Sum, true rails |
| sum_f | output | W | Sum, false rails |
| cout_t | output | 1 | Carry-out, true rail |
| cout_f | output | 1 | Carry-out, false rail |
| out_ack | input | 1 | Acknowledge from the consumer |

## Verification
The operand patterns fall into four groups. All-zero operands show that no stray generate appears. All-ones plus a carry-in, which totals exactly 2^W, sends one carry through every prefix level. Alternating bit patterns and all-ones plus all-ones separate wrong spans from wrong propagate terms. Random operands with random acknowledge delays exercise token ordering. A partly valid input shows that capture waits for input completeness. An empty pipeline with a stalled consumer pins the eight-edge latency and shows the four-token occupancy limit of a half-buffer chain.

// File: rtl/ks_dr_pkg.sv
package ks_dr_pkg;

  // Number of prefix combining levels needed to span w bit positions.
  function automatic int unsigned ks_levels(input int unsigned w);
    int unsigned n;
    n = 0;
    while ((32'd1 << n) < w) n++;
    return n;
  endfunction

  // Payload carried between prefix stages: group P, group G, bitwise p, carry-in.
  function automatic int unsigned pg_width(input int unsigned w);
    return 3 * w + 1;
  endfunction

endpackage

// File: rtl/ks_celem.sv
module ks_celem (
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  output logic y
);
  logic y_q;
  logic y_d;

  always_comb begin
    y_d = (a & b) | (y_q & (a | b));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) y_q <= 1'b0;
    else        y_q <= y_d;
  end

  assign y = y_q;
endmodule

// File: rtl/ks_hb_bank.sv
module ks_hb_bank #(
  parameter int unsigned BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] nxt_val,
  input  logic          in_full,
  input  logic          in_empty,
  input  logic          rack,
  output logic [BW-1:0] q_t,
  output logic [BW-1:0] q_f,
  output logic          lack
);
  logic [BW-1:0] t_q, f_q, t_d, f_d;
  logic          full_q, any_q, ld, clr;

  always_comb begin
    full_q = &(t_q | f_q);
    any_q  = |(t_q | f_q);
    ld     = in_full & ~rack & ~any_q;
    clr    = in_empty & rack & full_q;
    t_d    = t_q;
    f_d    = f_q;
    if (ld) begin
      t_d = nxt_val;
      f_d = ~nxt_val;
    end else if (clr) begin
      t_d = '0;
      f_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= '0;
      f_q <= '0;
    end else if (ld | clr) begin
      t_q <= t_d;
      f_q <= f_d;
    end
  end

  ks_celem u_ack (
    .clk  (clk),
    .rst_n(rst_n),
    .a    (full_q),
    .b    (any_q),
    .y    (lack)
  );

  assign q_t = t_q;
  assign q_f = f_q;
endmodule

// File: rtl/ks_level_logic.sv
module ks_level_logic #(
  parameter int unsigned W    = 64,
  parameter int unsigned DIST = 1
) (
  input  logic [3*W:0] pg_in,
  output logic [3*W:0] pg_out
);
  logic [W-1:0] gp, gg, np, ng;

  assign gp = pg_in[W-1:0];
  assign gg = pg_in[2*W-1:W];

  for (genvar i = 0; i < W; i++) begin : g_pos
    if (i >= DIST) begin : g_comb
      assign ng[i] = gg[i] | (gp[i] & gg[i-DIST]);
      assign np[i] = gp[i] & gp[i-DIST];
    end else begin : g_pass
      assign ng[i] = gg[i];
      assign np[i] = gp[i];
    end
  end

  assign pg_out = {pg_in[3*W:2*W], ng, np};
endmodule

// File: rtl/ks_dr_adder.sv
module ks_dr_adder
  import ks_dr_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] opa_t,
  input  logic [W-1:0] opa_f,
  input  logic [W-1:0] opb_t,
  input  logic [W-1:0] opb_f,
  input  logic         cin_t,
  input  logic         cin_f,
  output logic         in_ack,
  output logic [W-1:0] sum_t,
  output logic [W-1:0] sum_f,
  output logic         cout_t,
  output logic         cout_f,
  input  logic         out_ack
);
  localparam int unsigned LVLS = ks_levels(W);
  localparam int unsigned NPG  = LVLS + 1;
  localparam int unsigned NST  = LVLS + 2;
  localparam int unsigned PLW  = pg_width(W);

  logic [PLW-1:0] st_t [1:NPG];
  logic [PLW-1:0] st_f [1:NPG];
  logic           lack [1:NST];

  // Stage 1: bitwise propagate/generate, carry-in folded into bit 0
  logic           src_full, src_empty;
  logic [W-1:0]   bp, bg;
  logic [PLW-1:0] s1_nxt;

  always_comb begin
    src_full  = (&(opa_t | opa_f)) & (&(opb_t | opb_f)) & (cin_t | cin_f);
    src_empty = ~((|(opa_t | opa_f)) | (|(opb_t | opb_f)) | cin_t | cin_f);
    bp        = opa_t ^ opb_t;
    bg        = opa_t & opb_t;
    bg[0]     = bg[0] | (bp[0] & cin_t);
    s1_nxt    = {cin_t, bp, bg, bp};
  end

  ks_hb_bank #(.BW(PLW)) u_st1 (
    .clk     (clk),
    .rst_n   (rst_n),
    .nxt_val (s1_nxt),
    .in_full (src_full),
    .in_empty(src_empty),
    .rack    (lack[2]),
    .q_t     (st_t[1]),
    .q_f     (st_f[1]),
    .lack    (lack[1])
  );

  // Stages 2..NPG: one prefix level each
  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    logic [PLW-1:0] nxt;
    logic           pf, pe;
    assign pf = &(st_t[l+1] | st_f[l+1]);
    assign pe = ~|(st_t[l+1] | st_f[l+1]);

    ks_level_logic #(.W(W), .DIST(1 << l)) u_logic (
      .pg_in (st_t[l+1]),
      .pg_out(nxt)
    );

    ks_hb_bank #(.BW(PLW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .nxt_val (nxt),
      .in_full (pf),
      .in_empty(pe),
      .rack    (lack[l+3]),
      .q_t     (st_t[l+2]),
      .q_f     (st_f[l+2]),
      .lack    (lack[l+2])
    );
  end

  // Last stage: sum XOR and carry-out
  logic [W-1:0] fp, fg, fc;
  logic         fcin, lf, le;
  logic [W:0]   sum_nxt, o_t, o_f;
  logic [W-1:0] unused_grp_p;

  always_comb begin
    unused_grp_p = st_t[NPG][W-1:0];
    fg      = st_t[NPG][2*W-1:W];
    fp      = st_t[NPG][3*W-1:2*W];
    fcin    = st_t[NPG][3*W];
    fc      = {fg[W-2:0], fcin};
    sum_nxt = {fg[W-1], fp ^ fc};
    lf      = &(st_t[NPG] | st_f[NPG]);
    le      = ~|(st_t[NPG] | st_f[NPG]);
  end

  ks_hb_bank #(.BW(W+1)) u_stsum (
    .clk     (clk),
    .rst_n   (rst_n),
    .nxt_val (sum_nxt),
    .in_full (lf),
    .in_empty(le),
    .rack    (out_ack),
    .q_t     (o_t),
    .q_f     (o_f),
    .lack    (lack[NST])
  );

  assign in_ack = lack[1];
  assign sum_t  = o_t[W-1:0];
  assign sum_f  = o_f[W-1:0];
  assign cout_t = o_t[W];
  assign cout_f = o_f[W];
endmodule

// File: rtl/ks_dr_adder_chk.sv
module ks_dr_adder_chk #(
  parameter int unsigned W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] opa_t,
  input logic [W-1:0] opa_f,
  input logic [W-1:0] opb_t,
  input logic [W-1:0] opb_f,
  input logic         cin_t,
  input logic         cin_f,
  input logic         in_ack,
  input logic [W-1:0] sum_t,
  input logic [W-1:0] sum_f,
  input logic         cout_t,
  input logic         cout_f,
  input logic         out_ack
);
  logic in_full, in_empty, out_full, out_any;

  assign in_full  = (&(opa_t | opa_f)) & (&(opb_t | opb_f)) & (cin_t | cin_f);
  assign in_empty = ~((|(opa_t | opa_f)) | (|(opb_t | opb_f)) | cin_t | cin_f);
  assign out_full = (&(sum_t | sum_f)) & (cout_t | cout_f);
  assign out_any  = (|(sum_t | sum_f)) | cout_t | cout_f;

  p_rail_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((sum_t & sum_f) == '0) && !(cout_t && cout_f));

  p_bank_atomic_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_any |-> out_full);

  p_hold_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_full && !out_ack) |=> (out_full && $stable(sum_t) && $stable(cout_t)));

  p_no_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_any && out_ack) |=> !out_any);

  p_ack_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> $past(in_full));

  p_ack_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ack) |-> $past(in_empty));
endmodule

bind ks_dr_adder ks_dr_adder_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .opa_t  (opa_t),
  .opa_f  (opa_f),
  .opb_t  (opb_t),
  .opb_f  (opb_f),
  .cin_t  (cin_t),
  .cin_f  (cin_f),
  .in_ack (in_ack),
  .sum_t  (sum_t),
  .sum_f  (sum_f),
  .cout_t (cout_t),
  .cout_f (cout_f),
  .out_ack(out_ack)
);

// File: tb/ks_dr_adder_test.sv
`timescale 1ns/1ps
module ks_dr_adder_test;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] opa_t, opa_f, opb_t, opb_f;
  logic         cin_t, cin_f;
  logic         in_ack;
  logic [W-1:0] sum_t, sum_f;
  logic         cout_t, cout_f;
  logic         out_ack;

  int nchk  = 0;
  int nfail = 0;
  logic [W:0] expq[$];

  always #2 clk = ~clk;

  ks_dr_adder #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .opa_t(opa_t), .opa_f(opa_f), .opb_t(opb_t), .opb_f(opb_f),
    .cin_t(cin_t), .cin_f(cin_f), .in_ack(in_ack),
    .sum_t(sum_t), .sum_f(sum_f), .cout_t(cout_t), .cout_f(cout_f),
    .out_ack(out_ack)
  );

  function automatic logic [W:0] ref_add(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
  endfunction

  function automatic logic out_full();
    return (&(sum_t | sum_f)) & (cout_t | cout_f);
  endfunction

  function automatic logic out_empty();
    return ~((|(sum_t | sum_f)) | cout_t | cout_f);
  endfunction

  task automatic check(input logic ok, input string req, input logic [W:0] act, input logic [W:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_valid(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    opa_t = a; opa_f = ~a; opb_t = b; opb_f = ~b; cin_t = c; cin_f = ~c;
  endtask

  task automatic drive_empty();
    opa_t = '0; opa_f = '0; opb_t = '0; opb_f = '0; cin_t = 1'b0; cin_f = 1'b0;
  endtask

  task automatic put(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    @(negedge clk);
    expq.push_back(ref_add(a, b, c));
    drive_valid(a, b, c);
    while (in_ack !== 1'b1) @(negedge clk);
    drive_empty();
    while (in_ack !== 1'b0) @(negedge clk);
  endtask

  task automatic take(input int d1, input int d2);
    logic [W:0] got, exp;
    while (!out_full()) @(negedge clk);
    got = {cout_t, sum_t};
    if (expq.size() == 0) begin
      check(1'b0, "R8 extra result", got, '0);
      exp = got;
    end else begin
      exp = expq.pop_front();
    end
    check(got == exp, "R2 R8 sum value/order", got, exp);
    check({cout_f, sum_f} == ~got, "R9 false rails", {cout_f, sum_f}, ~got);
    repeat (d1) @(negedge clk);
    check({cout_t, sum_t} == got && out_full(), "R5 hold while out_ack low", {cout_t, sum_t}, got);
    out_ack = 1'b1;
    while (!out_empty()) @(negedge clk);
    for (int k = 0; k < d2; k++) begin
      @(negedge clk);
      check(out_empty(), "R6 empty while out_ack high", {cout_t, sum_t}, '0);
    end
    out_ack = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [W-1:0] ones, alt;
    int accepted;
    ones = '1;
    alt  = {(W/2){2'b01}};
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    out_ack = 1'b0;
    drive_empty();
    repeat (3) @(negedge clk);
    check(out_empty() && in_ack == 1'b0, "R1 reset state", {cout_t, sum_t}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_empty() && in_ack == 1'b0, "R1 after release", {cout_t, sum_t}, '0);

    // R7: latency with empty pipeline
    @(negedge clk);
    expq.push_back(ref_add(alt, ~alt, 1'b1));
    drive_valid(alt, ~alt, 1'b1);
    repeat (7) @(negedge clk);
    check(out_empty(), "R7 not valid after 7 edges", {cout_t, sum_t}, '0);
    @(negedge clk);
    check(out_full(), "R7 valid after 8 edges", {cout_t, sum_t}, ref_add(alt, ~alt, 1'b1));
    drive_empty();
    while (in_ack !== 1'b0) @(negedge clk);
    take(2, 2);

    // R3: partial input never captured
    @(negedge clk);
    opa_t = ones; opa_f = '0; cin_t = 1'b1; cin_f = 1'b0;
    opb_t = '0; opb_f = '0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check(in_ack == 1'b0 && out_empty(), "R3 partial input ignored", {cout_t, sum_t}, '0);
    end
    opb_t = '0; opb_f = ones;
    expq.push_back(ref_add(ones, '0, 1'b1));
    while (in_ack !== 1'b1) @(negedge clk);
    drive_empty();
    while (in_ack !== 1'b0) @(negedge clk);
    take(1, 1);

    // Directed corners: R2
    fork
      begin
        put('0, '0, 1'b0);
        put(ones, ones, 1'b1);
        put(alt, ~alt, 1'b0);
        put(ones, {{(W-1){1'b0}}, 1'b1}, 1'b0);
        put(alt, alt, 1'b1);
      end
      begin
        for (int k = 0; k < 5; k++) take(0, 0);
      end
    join

    // R10: stalled consumer, exactly 4 tokens accepted
    accepted = 0;
    for (int k = 0; k < 4; k++) begin
      put({$urandom, $urandom}, {$urandom, $urandom}, 1'(k));
      accepted++;
    end
    @(negedge clk);
    expq.push_back(ref_add(ones, alt, 1'b0));
    drive_valid(ones, alt, 1'b0);
    for (int k = 0; k < 30; k++) @(negedge clk);
    check(in_ack == 1'b0, "R10 fifth token stalled", {64'd0, in_ack}, '0);
    check(accepted == 4, "R10 four tokens held", accepted, 4);
    fork
      begin
        while (in_ack !== 1'b1) @(negedge clk);
        drive_empty();
        while (in_ack !== 1'b0) @(negedge clk);
      end
      begin
        for (int k = 0; k < 5; k++) take(1, 0);
      end
    join

    // R8: random stream with random acknowledge delays
    fork
      begin
        for (int k = 0; k < 300; k++) begin
          logic [W-1:0] a, b;
          a = {$urandom, $urandom};
          b = {$urandom, $urandom};
          if ((k % 17) == 0) b = ~a;
          put(a, b, 1'($urandom));
          repeat ($urandom % 3) @(negedge clk);
        end
      end
      begin
        for (int k = 0; k < 300; k++) take(int'($urandom % 4), int'($urandom % 3));
      end
    join

    repeat (40) @(negedge clk);
    check(out_empty(), "R8 no extra result", {cout_t, sum_t}, '0);
    check(expq.size() == 0, "R8 every token returned", expq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule